// File: doc/BRIEF.md
# Guarded Configuration Byte With Staged Unlock

This block keeps a one-byte configuration word next to a serial memory. The word holds two volatile enable latches (a general write enable and a second-stage register enable) and a set of settings that would survive power loss in silicon: a two-bit watchdog period code, a three-bit block-protect code and a hardware-lock enable. In this model those settings are ordinary flops.

A bus front end reports a register write as a transaction. It raises `wr_start`, gives each data byte with `wr_byte_vld`, and ends with `wr_stop`. The block answers every data byte with an acknowledge or a refusal. It commits the first byte at the stop, and only when that byte was the single byte of the transaction and was acknowledged. The settings change only after a three-step sequence: enable, second-stage enable, then the value.

The block also tells the memory write path, combinationally, whether the address on `mem_addr` may be written. It reports a write attempt on a locked address through `mem_wr_try`.

Top module: `prot_ctrl_reg`

## Requirements
- R1: After reset, `ctrl_q` reads 00h. The byte layout from bit 7 down to bit 0 is: lock enable, period code bit 1, period code bit 0, protect bit 1, protect bit 0, second-stage enable, write enable, protect bit 2.
- R2: A lone byte 02h is always acknowledged, and at the stop it sets the write enable (bit 1).
- R3: While the write enable is 0, every byte other than 02h is refused and changes nothing.
- R4: A lone byte 06h, given with the write enable set and the second-stage enable clear, is acknowledged and at the stop sets bit 2 and bit 1.
- R5: While the second-stage enable is set, a lone byte with bit 1 = 1 and bit 2 = 0 is a settings load. At the stop it copies its bits 7, 6, 5, 4, 3 and 0 into the same positions, clears bit 2 and keeps bit 1 set.
- R6: While the second-stage enable is set, a lone byte with bits 2 and 1 both set leaves the settings unchanged and keeps the second-stage enable set.
- R7: A second data byte in one transaction is refused, and the transaction then changes nothing. A transaction that stops before any data byte also changes nothing.
- R8: When `wp_pin` is 1 and the lock enable (bit 7) is 1, a settings-load byte is refused and the settings keep their values.
- R9: Protect code {bit0, bit4, bit3} selects the locked addresses of the default 8 KB space:
  - 000: nothing.
  - 001: 1800h-1FFFh.
  - 010: 1000h-1FFFh.
  - 011: all addresses.
  - 100: 000h-03Fh.
  - 101: 000h-07Fh.
  - 110: 000h-0FFh.
  - 111: 000h-1FFh.
- R10: `mem_wr_ok` is 1 exactly when the write enable is 1 and `mem_addr` is not locked.
- R11: A `mem_wr_try` pulse on a locked address clears the second-stage enable by the next cycle.
- R12: A lone byte 00h, given with the write enable set, clears the write enable. Any other byte outside the sequence above is acknowledged when the write enable is set, but has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_start | input | 1 | Register write transaction begins |
| wr_byte_vld | input | 1 | Data byte present |
| wr_byte | input | 8 | Data byte |
| wr_stop | input | 1 | Transaction ends; commit point |
| wp_pin | input | 1 | Hardware write-protect pin |
| mem_addr | input | ADDR_W | Array address under test |
| mem_wr_try | input | 1 | Array write attempt at mem_addr |
| ctrl_q | output | 8 | Configuration byte |
| ack_vld | output | 1 | Answer for the previous data byte is present |
| ack_ok | output | 1 | 1 = acknowledged, 0 = refused |
| mem_wr_ok | output | 1 | Array write allowed at mem_addr |

## Verification
Three properties are checked on every cycle:
- An extra byte in a transaction is always refused, and a settings-load byte is always refused while the hardware lock is active.
- The settings move only on a committed load, and a locked write attempt always clears the second-stage enable.
- The array write-allow never rises while the write enable is low.

Only the bench scenarios show the ordered effect of whole byte sequences and the full address map of each protect code. They cover 02h-06h-value runs, the hold case with bit 2 set, and clearing by 00h.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_SETWEL  = 3'd1,
      OP_SETRWEL = 3'd2,
      OP_CLRWEL  = 3'd3,
      OP_LOAD    = 3'd4
   } pcr_op_e;

   localparam int B_LOCK = 7;
   localparam int B_WD1  = 6;
   localparam int B_WD0  = 5;
   localparam int B_BP1  = 4;
   localparam int B_BP0  = 3;
   localparam int B_RWE  = 2;
   localparam int B_WE   = 1;
   localparam int B_BP2  = 0;

   localparam logic [7:0] CMD_WE   = 8'h02;
   localparam logic [7:0] CMD_RWE  = 8'h06;
   localparam logic [7:0] CMD_CLR  = 8'h00;
endpackage

// File: rtl/pcr_xact.sv
module pcr_xact
   import pcr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_start,
   input  logic       wr_byte_vld,
   input  logic [7:0] wr_byte,
   input  logic       wr_stop,
   input  logic       wel,
   input  logic       rwel,
   input  logic       hw_lock,
   output logic       ack_vld,
   output logic       ack_ok,
   output logic       commit,
   output pcr_op_e    commit_op,
   output logic [7:0] commit_data
);
   logic       active_q;
   logic [1:0] cnt_q;
   logic       acc_q;
   pcr_op_e    op_q;
   logic [7:0] data_q;
   logic       acc_c;
   pcr_op_e    op_c;
   logic       is_load;
   logic       take_byte;

   always_comb begin
      is_load = rwel && wr_byte[B_WE] && !wr_byte[B_RWE];
      if (is_load) begin
         acc_c = wel && !hw_lock;
         op_c  = OP_LOAD;
      end else if (rwel && wr_byte[B_WE] && wr_byte[B_RWE]) begin
         acc_c = wel;
         op_c  = OP_NONE;
      end else if (wr_byte == CMD_WE) begin
         acc_c = 1'b1;
         op_c  = OP_SETWEL;
      end else if (wr_byte == CMD_RWE) begin
         acc_c = wel;
         op_c  = OP_SETRWEL;
      end else if (wr_byte == CMD_CLR) begin
         acc_c = wel;
         op_c  = OP_CLRWEL;
      end else begin
         acc_c = wel;
         op_c  = OP_NONE;
      end
   end

   assign take_byte = active_q && wr_byte_vld && !wr_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= 2'd0;
         acc_q    <= 1'b0;
         op_q     <= OP_NONE;
         data_q   <= 8'h00;
         ack_vld  <= 1'b0;
         ack_ok   <= 1'b0;
      end else begin
         ack_vld <= take_byte;
         ack_ok  <= take_byte && (cnt_q == 2'd0) && acc_c;
         if (wr_start) begin
            active_q <= 1'b1;
            cnt_q    <= 2'd0;
            acc_q    <= 1'b0;
         end else if (take_byte) begin
            if (cnt_q == 2'd0) begin
               cnt_q  <= 2'd1;
               acc_q  <= acc_c;
               op_q   <= op_c;
               data_q <= wr_byte;
            end else begin
               cnt_q <= 2'd2;
            end
         end else if (wr_stop) begin
            active_q <= 1'b0;
            cnt_q    <= 2'd0;
         end
      end
   end

   assign commit      = active_q && wr_stop && !wr_start && !wr_byte_vld
                        && (cnt_q == 2'd1) && acc_q;
   assign commit_op   = op_q;
   assign commit_data = data_q;

   // R7
   extra_byte_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_byte && cnt_q != 2'd0) |=> (ack_vld && !ack_ok));

   // R8
   hw_lock_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_byte && cnt_q == 2'd0 && hw_lock && rwel
       && wr_byte[B_WE] && !wr_byte[B_RWE]) |=> !ack_ok);
endmodule

// File: rtl/pcr_state.sv
module pcr_state
   import pcr_pkg::*;
#(
   parameter logic [5:0] NV_INIT = 6'b000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit,
   input  pcr_op_e    commit_op,
   input  logic [7:0] commit_data,
   input  logic       clr_rwel,
   output logic [7:0] ctrl,
   output logic       wel,
   output logic       rwel,
   output logic [2:0] bp,
   output logic       lock_en
);
   logic [1:0] wd_q;
   logic [2:0] bp_q;
   logic       lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= NV_INIT[5];
         wd_q   <= NV_INIT[4:3];
         bp_q   <= NV_INIT[2:0];
         wel    <= 1'b0;
         rwel   <= 1'b0;
      end else begin
         if (commit) begin
            case (commit_op)
               OP_LOAD: begin
                  lock_q <= commit_data[B_LOCK];
                  wd_q   <= {commit_data[B_WD1], commit_data[B_WD0]};
                  bp_q   <= {commit_data[B_BP2], commit_data[B_BP1], commit_data[B_BP0]};
                  rwel   <= 1'b0;
               end
               OP_SETWEL:  wel <= 1'b1;
               OP_SETRWEL: begin
                  rwel <= 1'b1;
                  wel  <= 1'b1;
               end
               OP_CLRWEL:  wel <= 1'b0;
               default: ;
            endcase
         end
         if (clr_rwel) rwel <= 1'b0;
      end
   end

   always_comb begin
      ctrl         = 8'h00;
      ctrl[B_LOCK] = lock_q;
      ctrl[B_WD1]  = wd_q[1];
      ctrl[B_WD0]  = wd_q[0];
      ctrl[B_BP1]  = bp_q[1];
      ctrl[B_BP0]  = bp_q[0];
      ctrl[B_RWE]  = rwel;
      ctrl[B_WE]   = wel;
      ctrl[B_BP2]  = bp_q[2];
   end

   assign bp      = bp_q;
   assign lock_en = lock_q;

   // R5
   nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && commit_op == OP_LOAD) |=> $stable({lock_q, wd_q, bp_q}));

   // R4
   rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rwel) |-> $past(wel));

   // R11
   violation_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rwel |=> !rwel);
endmodule

// File: rtl/pcr_guard.sv
module pcr_guard #(
   parameter int ADDR_W = 13,
   parameter int PAGE_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        bp,
   output logic              locked
);
   localparam int N_LOW = 4;
   localparam int TOP   = ADDR_W - 1;

   if (ADDR_W < PAGE_W + N_LOW) begin : g_bad_size
      $error("pcr_guard: ADDR_W too small for eight lowest pages");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("pcr_guard: PAGE_W must be positive");
   end

   logic [N_LOW-1:0] low_hit;

   for (genvar k = 0; k < N_LOW; k++) begin : g_low
      assign low_hit[k] = (addr[TOP:PAGE_W+k] == '0);
   end

   always_comb begin
      case (bp)
         3'b000:  locked = 1'b0;
         3'b001:  locked = &addr[TOP:TOP-1];
         3'b010:  locked = addr[TOP];
         3'b011:  locked = 1'b1;
         default: locked = low_hit[bp[1:0]];
      endcase
   end
endmodule

// File: rtl/prot_ctrl_reg.sv
module prot_ctrl_reg
   import pcr_pkg::*;
#(
   parameter int         ADDR_W       = 13,
   parameter int         PAGE_W       = 6,
   parameter logic [5:0] NV_INIT      = 6'b000000,
   parameter bit         CLR_ON_ABUSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_byte_vld,
   input  logic [7:0]        wr_byte,
   input  logic              wr_stop,
   input  logic              wp_pin,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_wr_try,
   output logic [7:0]        ctrl_q,
   output logic              ack_vld,
   output logic              ack_ok,
   output logic              mem_wr_ok
);
   logic       wel, rwel, lock_en, hw_lock, locked, commit, clr_rwel;
   logic [2:0] bp;
   pcr_op_e    commit_op;
   logic [7:0] commit_data;

   assign hw_lock = wp_pin && lock_en;

   pcr_xact u_xact (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_byte_vld(wr_byte_vld),
      .wr_byte(wr_byte), .wr_stop(wr_stop), .wel(wel), .rwel(rwel),
      .hw_lock(hw_lock), .ack_vld(ack_vld), .ack_ok(ack_ok), .commit(commit),
      .commit_op(commit_op), .commit_data(commit_data)
   );

   pcr_state #(.NV_INIT(NV_INIT)) u_state (
      .clk(clk), .rst_n(rst_n), .commit(commit), .commit_op(commit_op),
      .commit_data(commit_data), .clr_rwel(clr_rwel), .ctrl(ctrl_q),
      .wel(wel), .rwel(rwel), .bp(bp), .lock_en(lock_en)
   );

   pcr_guard #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_guard (
      .addr(mem_addr), .bp(bp), .locked(locked)
   );

   if (CLR_ON_ABUSE) begin : g_clr
      assign clr_rwel = mem_wr_try && locked;
   end else begin : g_noclr
      assign clr_rwel = 1'b0;
   end

   assign mem_wr_ok = wel && !locked;

   // R10
   wr_ok_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_ok |-> ctrl_q[B_WE]);
endmodule

// File: tb/sim_prot_ctrl_reg.sv
`timescale 1ns/1ps
module sim_prot_ctrl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_start = 0, wr_byte_vld = 0, wr_stop = 0, wp_pin = 0, mem_wr_try = 0;
   logic [7:0]  wr_byte = 8'h00;
   logic [12:0] mem_addr = '0;
   logic [7:0]  ctrl_q;
   logic        ack_vld, ack_ok, mem_wr_ok;
   int          checks = 0, failures = 0;
   bit          done = 0;

   // model of the byte, built from the requirements
   logic [7:0] m = 8'h00;

   always #2.5 clk = ~clk;

   prot_ctrl_reg u0 (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_byte_vld(wr_byte_vld),
      .wr_byte(wr_byte), .wr_stop(wr_stop), .wp_pin(wp_pin), .mem_addr(mem_addr),
      .mem_wr_try(mem_wr_try), .ctrl_q(ctrl_q), .ack_vld(ack_vld), .ack_ok(ack_ok),
      .mem_wr_ok(mem_wr_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic is_load(input logic [7:0] d);
      return m[2] && d[1] && !d[2];
   endfunction

   function automatic logic exp_ack(input logic [7:0] d);
      if (is_load(d)) return m[1] && !(wp_pin && m[7]);   // R5 R8
      if (m[2] && d[1] && d[2]) return m[1];                // R6
      if (d == 8'h02) return 1'b1;                          // R2
      return m[1];                                          // R3 R12
   endfunction

   function automatic void apply(input logic [7:0] d);
      if (is_load(d)) m = {d[7:3], 1'b0, 1'b1, d[0]};
      else if (m[2] && d[1] && d[2]) m = m;
      else if (d == 8'h02) m[1] = 1'b1;
      else if (d == 8'h06) m[2:1] = 2'b11;
      else if (d == 8'h00) m[1] = 1'b0;
   endfunction

   function automatic logic exp_lock(input logic [2:0] code, input logic [12:0] a);
      case (code)
         3'b000: return 1'b0;
         3'b001: return a >= 13'h1800;
         3'b010: return a >= 13'h1000;
         3'b011: return 1'b1;
         3'b100: return a <= 13'h03F;
         3'b101: return a <= 13'h07F;
         3'b110: return a <= 13'h0FF;
         default: return a <= 13'h1FF;
      endcase
   endfunction

   // nb = number of data bytes (0, 1 or 2)
   task automatic tx(input int nb, input logic [7:0] b0, input logic [7:0] b1, input string req);
      logic e;
      @(negedge clk) wr_start = 1;
      @(negedge clk) wr_start = 0;
      e = exp_ack(b0);
      for (int i = 0; i < nb; i++) begin
         wr_byte = (i == 0) ? b0 : b1;
         wr_byte_vld = 1;
         @(negedge clk) wr_byte_vld = 0;
         chk({req, " ack_vld"}, ack_vld, 1);
         chk({req, " ack"}, ack_ok, (i == 0) ? e : 1'b0);
      end
      wr_stop = 1;
      @(negedge clk) wr_stop = 0;
      if (nb == 1 && e) apply(b0);
      chk({req, " ctrl"}, ctrl_q, m);
   endtask

   task automatic mem_chk(input logic [12:0] a, input string req);
      @(negedge clk) mem_addr = a;
      #1 chk(req, mem_wr_ok, m[1] && !exp_lock({m[0], m[4], m[3]}, a));
   endtask

   task automatic mem_try(input logic [12:0] a);
      @(negedge clk) mem_addr = a; mem_wr_try = 1;
      if (exp_lock({m[0], m[4], m[3]}, a)) m[2] = 1'b0;
      @(negedge clk) mem_wr_try = 0;
      chk("R11 rwel after try", ctrl_q, m);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset ctrl", ctrl_q, 8'h00);
      chk("R1 reset ack", ack_vld, 0);
      tx(1, 8'h06, 8'h00, "R3 no wel");
      mem_chk(13'h0005, "R10 wel low");
      tx(1, 8'h02, 8'h00, "R2 set wel");
      tx(1, 8'h06, 8'h00, "R4 set rwel");
      tx(1, 8'h8F, 8'h00, "R6 hold");
      tx(1, 8'hDB, 8'h00, "R5 load");
      mem_chk(13'h01FF, "R9 code111 top");
      mem_chk(13'h0200, "R9 code111 above");
      tx(2, 8'h02, 8'h06, "R7 two bytes");
      tx(0, 8'h00, 8'h00, "R7 empty");
      wp_pin = 1;
      tx(1, 8'h06, 8'h00, "R4 rwel again");
      tx(1, 8'h02, 8'h00, "R8 locked load");
      mem_try(13'h0010);
      wp_pin = 0;
      tx(1, 8'h06, 8'h00, "R4 rwel");
      tx(1, 8'h0A, 8'h00, "R5 code001");
      mem_chk(13'h17FF, "R9 code001 below");
      mem_chk(13'h1800, "R9 code001 edge");
      tx(1, 8'h37, 8'h00, "R12 ignored");
      tx(1, 8'h00, 8'h00, "R12 clear wel");
      for (int it = 0; it < 400; it++) begin
         int sel = $urandom_range(0, 9);
         wp_pin = ($urandom_range(0, 3) == 0);
         if (sel < 6) begin
            case ($urandom_range(0, 4))
               0: d = 8'h02;
               1: d = 8'h06;
               2: d = 8'h00;
               3: d = {$urandom_range(0, 255)} & 8'hFB | 8'h02;
               default: d = $urandom_range(0, 255);
            endcase
            tx(($urandom_range(0, 7) == 0) ? 2 : 1, d, 8'h02, "R5 R6 R12 random");
         end else if (sel < 9) begin
            mem_chk($urandom_range(0, 8191), "R9 R10 random");
         end else begin
            mem_try($urandom_range(0, 8191));
         end
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule